// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps one private cache coherent with its peers in a small shared-memory multiprocessor. The peers share a single bus. The policy is write-invalidate with write-back. A direct-mapped tag store holds one state per line: Invalid, Shared (clean and readable) or Exclusive (dirty, writable, and the only copy in the system). CPU reads and writes that hit finish locally. When a request misses, the block asks the bus for a read-miss or write-miss transaction. If the line it must displace holds a dirty block with another address, that block is written back first.

The block also watches the transactions that other caches place on the bus. When it holds a dirty copy that another cache wants, it supplies the data by writing it back and tells memory to drop its own reply. It also invalidates or downgrades the line as the transaction requires. The bus grants one requester at a time, so writes to any one block are ordered by the bus. A snooped transaction always goes ahead of the local CPU in the same cycle.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done`, `bus_req` and `mem_abort` are low.
- R2: A read that misses (line Invalid or tag differs) raises `bus_req` with `bus_cmd` = 2'b01 (read miss) and `bus_addr` = the request address. On the granted edge the line takes the new tag in Shared.
- R3: A write to a line that is Invalid, holds another tag, or is Shared raises a write miss, `bus_cmd` = 2'b10. On the granted edge the line becomes Exclusive. There is no upgrade transaction.
- R4: A read hit (Shared or Exclusive, tag equal) or a write hit (Exclusive, tag equal) raises `cpu_done` on the clock after acceptance. It raises no `bus_req` and changes no state.
- R5: A miss whose line is Exclusive with another tag first issues a write-back, `bus_cmd` = 2'b11, of the old block address. The new miss follows on the next granted cycle.
- R6: A snooped write miss with an equal tag on a Shared line moves it to Invalid without `mem_abort`.
- R7: A snooped write miss with an equal tag on an Exclusive line pulses `mem_abort` and moves the line to Invalid.
- R8: A snooped read miss with an equal tag on an Exclusive line pulses `mem_abort` and moves the line to Shared.
- R9: A snoop with a different tag, a snoop that hits an Invalid line, and a snooped write-back (2'b11) all cause no abort and no state change.
- R10: In a cycle with `snp_valid` high, no CPU request is accepted and no grant is taken. The CPU request waits and then sees the state the snoop left.
- R11: `mem_abort` is a one-cycle pulse on the clock after the snoop. `cpu_done` is a one-cycle pulse on the clock after a hit is accepted or the miss is granted.
- R12: While `bus_req` is high and not granted, it stays high. When two caches write one block, they complete in grant order, and the later write miss takes the earlier writer's dirty copy with an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the shared bus |
| bus_grant | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back, 00 none |
| bus_addr | output | ADDR_W | Block address of the transaction |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped block address |
| mem_abort | output | 1 | This cache supplies a dirty block; memory reply dropped |

## Verification
The bench targets the write to a Shared line. A design that treated this as a hit would raise no transaction and leave a stale copy in the peer cache. It also targets eviction of a dirty line with another tag. Skipping the write-back there loses data, and writing back a victim with the same tag would waste a bus cycle. A snoop is driven in the same cycle as a CPU request, including one to the line the CPU is about to write. A design that let the CPU go first would finish a write hit on a line that has just been downgraded. The bench also sends snoops with a different tag, snoops to Invalid lines and snooped write-backs. A design that compared only the index would abort or invalidate on these. The bench checks that a read miss from a peer downgrades an Exclusive line to Shared, not to Invalid. Finally, both caches write one block at the same time, which exposes any missing serialization through the bus.

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mem_abort
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] L_INV = 2'd0, L_SHR = 2'd1, L_EXC = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_RDM = 2'd1, C_WRM = 2'd2, C_WBK = 2'd3;
  localparam logic [1:0] P_IDLE = 2'd0, P_WBK = 2'd1, P_MISS = 2'd2;

  logic [1:0]        lst [LINES];
  logic [TAG_W-1:0]  ltg [LINES];
  logic [1:0]        ph;
  logic              rwe;
  logic [ADDR_W-1:0] radr;
  logic              done_q, abort_q;

  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire s_act = snp_valid && (snp_cmd == C_RDM || snp_cmd == C_WRM) &&
               lst[s_idx] != L_INV && ltg[s_idx] == s_tag;

  wire [IDX_W-1:0] c_idx  = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag  = cpu_addr[ADDR_W-1:IDX_W];
  wire             c_same = ltg[c_idx] == c_tag;
  wire c_hit   = (lst[c_idx] == L_EXC) ? c_same : (lst[c_idx] == L_SHR && c_same && !cpu_we);
  wire c_evict = lst[c_idx] == L_EXC && !c_same;
  wire accept  = ph == P_IDLE && cpu_req && !done_q;

  wire [IDX_W-1:0] r_idx   = radr[IDX_W-1:0];
  wire [TAG_W-1:0] r_tag   = radr[ADDR_W-1:IDX_W];
  wire             r_dirty = lst[r_idx] == L_EXC && ltg[r_idx] != r_tag;

  assign bus_req   = ph == P_MISS || (ph == P_WBK && r_dirty);
  assign bus_cmd   = !bus_req ? C_NONE : (ph == P_WBK) ? C_WBK : (rwe ? C_WRM : C_RDM);
  assign bus_addr  = (ph == P_WBK) ? {ltg[r_idx], r_idx} : radr;
  assign cpu_done  = done_q;
  assign mem_abort = abort_q;

  wire won = bus_req && bus_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      rwe     <= 1'b0;
      radr    <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        lst[i] <= L_INV;
        ltg[i] <= '0;
      end
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (s_act) begin
        abort_q <= lst[s_idx] == L_EXC;
        if (snp_cmd == C_WRM)
          lst[s_idx] <= L_INV;
        else if (lst[s_idx] == L_EXC)
          lst[s_idx] <= L_SHR;
      end
      if (!snp_valid) begin
        case (ph)
          P_IDLE: if (accept) begin
            radr <= cpu_addr;
            rwe  <= cpu_we;
            if (c_hit)        done_q <= 1'b1;
            else if (c_evict) ph     <= P_WBK;
            else              ph     <= P_MISS;
          end
          P_WBK: begin
            if (won) begin
              lst[r_idx] <= L_INV;
              ph         <= P_MISS;
            end else if (!r_dirty) begin
              ph <= P_MISS;
            end
          end
          P_MISS: if (won) begin
            ltg[r_idx] <= r_tag;
            lst[r_idx] <= rwe ? L_EXC : L_SHR;
            done_q     <= 1'b1;
            ph         <= P_IDLE;
          end
          default: ph <= P_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/coh_ctrl_props.sv
module coh_ctrl_props (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_grant,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic       mem_abort
);
  p_abort_follows_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort |-> $past(snp_valid));

  p_snoop_blocks_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !cpu_done);

  p_done_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  p_abort_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort && !snp_valid |=> !mem_abort);

  p_done_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req);

  p_writeback_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_grant && !snp_valid && bus_cmd == 2'b11 |=> bus_req && bus_cmd != 2'b11);

  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant && !snp_valid |=> bus_req);
endmodule

bind snoop_coh_ctrl coh_ctrl_props u_props (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_grant(bus_grant), .bus_cmd(bus_cmd), .snp_valid(snp_valid), .mem_abort(mem_abort)
);

// File: tb/snoop_coh_ctrl_test.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       creq [2];
  logic       cwe  [2];
  logic [7:0] cad  [2];
  logic       done [2];
  logic       req  [2];
  logic       ab   [2];
  logic [1:0] cmd  [2];
  logic [7:0] adr  [2];
  logic       grant[2];
  logic       sv   [2];
  logic [1:0] scmd [2];
  logic [7:0] sad  [2];
  logic       inj_v = 1'b0;
  logic [1:0] inj_cmd = 2'd0;
  logic [7:0] inj_adr = 8'd0;

  assign grant[0] = req[0] && !inj_v;
  assign grant[1] = req[1] && !req[0] && !inj_v;

  for (genvar g = 0; g < 2; g++) begin : cc
    assign sv[g]   = inj_v || (grant[1-g] && cmd[1-g] != 2'b11);
    assign scmd[g] = inj_v ? inj_cmd : cmd[1-g];
    assign sad[g]  = inj_v ? inj_adr : adr[1-g];
    snoop_coh_ctrl #(.ADDR_W(8), .IDX_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(creq[g]), .cpu_we(cwe[g]), .cpu_addr(cad[g]),
      .cpu_done(done[g]), .bus_req(req[g]), .bus_grant(grant[g]), .bus_cmd(cmd[g]),
      .bus_addr(adr[g]), .snp_valid(sv[g]), .snp_cmd(scmd[g]), .snp_addr(sad[g]),
      .mem_abort(ab[g]));
  end

  int nchk = 0, nfail = 0;
  int logq[$];
  int ab_cnt[2];

  task automatic check(bit ok, string rq, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // behavioural reference: per cache line states (0 I, 1 S, 2 E), tags, phase
  int mst[2][8], mtg[2][8], mph[2], mwe[2], mad[2], mdn[2], mab[2];

  function automatic bit m_vdirty(int c);
    return mst[c][mad[c] % 8] == 2 && mtg[c][mad[c] % 8] != mad[c] / 8;
  endfunction
  function automatic bit m_req(int c);
    return mph[c] == 2 || (mph[c] == 1 && m_vdirty(c));
  endfunction
  function automatic int m_cmd(int c);
    if (!m_req(c)) return 0;
    if (mph[c] == 1) return 3;
    return mwe[c] ? 2 : 1;
  endfunction
  function automatic int m_addr(int c);
    if (mph[c] == 1) return mtg[c][mad[c] % 8] * 8 + mad[c] % 8;
    return mad[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        mph[c] = 0; mwe[c] = 0; mad[c] = 0; mdn[c] = 0; mab[c] = 0;
        for (int i = 0; i < 8; i++) begin mst[c][i] = 0; mtg[c][i] = 0; end
      end
    end else begin
      bit er[2], mg[2];
      int ec[2], ea[2];
      for (int c = 0; c < 2; c++) begin er[c] = m_req(c); ec[c] = m_cmd(c); ea[c] = m_addr(c); end
      mg[0] = er[0] && !inj_v;
      mg[1] = er[1] && !er[0] && !inj_v;
      for (int c = 0; c < 2; c++) begin
        int o, sc, sa, si, pd, ix, tg;
        bit s_on;
        o = 1 - c;
        s_on = inj_v || (mg[o] && ec[o] != 3);
        sc = inj_v ? int'(inj_cmd) : ec[o];
        sa = inj_v ? int'(inj_adr) : ea[o];
        si = sa % 8;
        pd = mdn[c];
        mdn[c] = 0; mab[c] = 0;
        if (s_on && (sc == 1 || sc == 2) && mst[c][si] != 0 && mtg[c][si] == sa / 8) begin
          mab[c] = (mst[c][si] == 2);
          if (sc == 2) mst[c][si] = 0;
          else if (mst[c][si] == 2) mst[c][si] = 1;
        end
        if (!s_on) begin
          if (mph[c] == 0) begin
            if (creq[c] && pd == 0) begin
              mad[c] = cad[c]; mwe[c] = cwe[c];
              ix = mad[c] % 8; tg = mad[c] / 8;
              if (mtg[c][ix] == tg && (mst[c][ix] == 2 || (mst[c][ix] == 1 && !cwe[c]))) mdn[c] = 1;
              else if (mst[c][ix] == 2) mph[c] = 1;
              else mph[c] = 2;
            end
          end else if (mph[c] == 1) begin
            if (mg[c]) begin mst[c][mad[c] % 8] = 0; mph[c] = 2; end
            else if (!m_vdirty(c)) mph[c] = 2;
          end else if (mg[c]) begin
            mtg[c][mad[c] % 8] = mad[c] / 8;
            mst[c][mad[c] % 8] = mwe[c] ? 2 : 1;
            mdn[c] = 1;
            mph[c] = 0;
          end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (grant[c]) logq.push_back(c * 1024 + int'(cmd[c]) * 256 + int'(adr[c]));
        if (ab[c]) ab_cnt[c]++;
      end
    end
  end

  // cycle compare against the reference (R11 cycle timing of every output)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        bit ok;
        ok = done[c] == mdn[c][0] && ab[c] == mab[c][0] && req[c] == m_req(c);
        if (req[c]) ok = ok && int'(cmd[c]) == m_cmd(c) && int'(adr[c]) == m_addr(c);
        check(ok, "R11", $sformatf("cycle model cache%0d req/cmd", c),
              int'(req[c]) * 4 + int'(cmd[c]), int'(m_req(c)) * 4 + m_cmd(c));
      end
    end
  end

  function automatic int T(int w, int c, int a);
    return w * 1024 + c * 256 + a;
  endfunction

  task automatic chk_log(string rq, int e0, int e1);
    int n;
    n = (e0 >= 0) + (e1 >= 0);
    check(logq.size() == n, rq, "bus transaction count", logq.size(), n);
    if (logq.size() == n) begin
      if (n > 0) check(logq[0] == e0, rq, "first transaction", logq[0], e0);
      if (n > 1) check(logq[1] == e1, rq, "second transaction", logq[1], e1);
    end
    logq.delete();
  endtask

  task automatic chk_ab(string rq, int e0, int e1);
    check(ab_cnt[0] == e0, rq, "abort pulses cache0", ab_cnt[0], e0);
    check(ab_cnt[1] == e1, rq, "abort pulses cache1", ab_cnt[1], e1);
    ab_cnt[0] = 0; ab_cnt[1] = 0;
  endtask

  task automatic op(int c, bit we, logic [7:0] a, int exp_lat, string rq);
    int lat;
    @(negedge clk);
    creq[c] = 1'b1; cwe[c] = we; cad[c] = a;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done[c] && lat < 50);
    creq[c] = 1'b0;
    check(lat == exp_lat, rq, "completion latency", lat, exp_lat);
    @(negedge clk);
  endtask

  task automatic inject(logic [1:0] sc, logic [7:0] a, bit exp_ab0, string rq);
    @(negedge clk);
    inj_v = 1'b1; inj_cmd = sc; inj_adr = a;
    @(negedge clk);
    inj_v = 1'b0;
    check(ab[0] == exp_ab0, rq, "abort after snoop", int'(ab[0]), int'(exp_ab0));
    @(negedge clk);
    check(ab[0] == 1'b0, rq, "abort pulse ended", int'(ab[0]), 0);
  endtask

  localparam logic [7:0] A = 8'h11, B = 8'h19, C = 8'h22, D = 8'h2A;

  initial begin
    int lat0, lat1, lat;
    for (int c = 0; c < 2; c++) begin creq[c] = 0; cwe[c] = 0; cad[c] = 0; ab_cnt[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      check(!done[c] && !req[c] && !ab[c], "R1", "outputs idle after reset",
            int'(done[c]) + int'(req[c]) + int'(ab[c]), 0);
    end
    ab_cnt[0] = 0; ab_cnt[1] = 0; logq.delete();

    op(0, 0, A, 2, "R2"); chk_log("R2", T(0,1,A), -1); chk_ab("R2", 0, 0);
    op(0, 0, A, 1, "R4"); chk_log("R4", -1, -1);
    op(1, 0, A, 2, "R2"); chk_log("R2", T(1,1,A), -1); chk_ab("R2", 0, 0);
    op(0, 1, A, 2, "R3"); chk_log("R3", T(0,2,A), -1); chk_ab("R6", 0, 0);
    op(0, 1, A, 1, "R4"); chk_log("R4", -1, -1);
    op(1, 0, A, 2, "R6"); chk_log("R6", T(1,1,A), -1); chk_ab("R8", 1, 0);
    op(0, 0, A, 1, "R8");
    op(1, 1, A, 2, "R3"); chk_log("R3", T(1,2,A), -1); chk_ab("R6", 0, 0);
    op(0, 0, A, 2, "R6"); chk_log("R6", T(0,1,A), -1); chk_ab("R8", 0, 1);
    op(0, 1, A, 2, "R3"); chk_log("R3", T(0,2,A), -1);
    op(1, 1, A, 2, "R7"); chk_log("R7", T(1,2,A), -1); chk_ab("R7", 1, 0);
    op(0, 0, A, 2, "R7"); chk_log("R7", T(0,1,A), -1); chk_ab("R8", 0, 1);

    op(0, 1, B, 2, "R3"); chk_log("R3", T(0,2,B), -1); chk_ab("R9", 0, 0);
    op(1, 0, A, 1, "R9");
    op(0, 0, A, 3, "R5"); chk_log("R5", T(0,3,B), T(0,1,A)); chk_ab("R5", 0, 0);

    op(0, 1, C, 2, "R3"); chk_log("R3", T(0,2,C), -1);
    inject(2'b11, C, 1'b0, "R9");
    inject(2'b10, D, 1'b0, "R9");
    inject(2'b01, 8'h33, 1'b0, "R9");
    op(0, 1, C, 1, "R9"); chk_ab("R9", 0, 0); logq.delete();

    // R10: snoop in the same cycle as a CPU hit, unrelated address
    @(negedge clk);
    creq[0] = 1; cwe[0] = 1; cad[0] = C;
    inj_v = 1; inj_cmd = 2'b01; inj_adr = 8'h05;
    lat = 0;
    do begin @(negedge clk); inj_v = 0; lat++; end while (!done[0] && lat < 50);
    creq[0] = 0;
    check(lat == 2, "R10", "hit stalled by snoop", lat, 2);
    @(negedge clk);
    // R10: snoop downgrades the line the CPU writes in that cycle
    creq[0] = 1; cwe[0] = 1; cad[0] = C;
    inj_v = 1; inj_cmd = 2'b01; inj_adr = C;
    lat = 0;
    do begin @(negedge clk); inj_v = 0; lat++; end while (!done[0] && lat < 50);
    creq[0] = 0;
    check(lat == 3, "R10", "write after downgrade becomes miss", lat, 3);
    @(negedge clk);
    chk_log("R10", T(0,2,C), -1); chk_ab("R8", 1, 0);

    inject(2'b10, C, 1'b1, "R11");
    op(0, 0, C, 2, "R7"); chk_log("R7", T(0,1,C), -1); chk_ab("R7", 1, 0);

    // R12: both caches write one block in the same cycle
    @(negedge clk);
    creq[0] = 1; cwe[0] = 1; cad[0] = D;
    creq[1] = 1; cwe[1] = 1; cad[1] = D;
    lat0 = 0; lat1 = 0; lat = 0;
    while ((lat0 == 0 || lat1 == 0) && lat < 50) begin
      @(negedge clk); lat++;
      if (done[0] && lat0 == 0) begin lat0 = lat; creq[0] = 0; end
      if (done[1] && lat1 == 0) begin lat1 = lat; creq[1] = 0; end
    end
    check(lat0 == 2, "R12", "first writer latency", lat0, 2);
    check(lat1 == 3, "R12", "second writer latency", lat1, 3);
    @(negedge clk);
    chk_log("R12", T(0,2,D), T(1,2,D)); chk_ab("R12", 1, 0);
    op(1, 1, D, 1, "R12");
    op(0, 0, D, 2, "R12"); chk_log("R12", T(0,1,D), -1); chk_ab("R8", 0, 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule